// File: doc/BRIEF.md
# Outstanding Memory Request Tracker

This block sits between a processor port and a cache controller and keeps track of every memory request still in flight. Each new request carries a type, a byte address, a length and an access mode. In the next cycle the block answers with one status. It either issues the request or refuses it because another request to the same cache line is already outstanding, because the tracker is full, or because the request is malformed. An issued request is recorded in one of two fully associative tables, one for reads and one for writes, keyed by line address. In the same response cycle the block sends a translated request class downstream.

Completions from the cache side name a line address and say whether they are for a read or a write. A completion frees the matching entry. A completion that matches no entry sets a sticky error and changes nothing else. An age watchdog compares each live entry's issue time with a free-running cycle counter. When the first entry becomes too old, it latches a sticky deadlock flag together with that entry's line address. Four saturating counters record alias refusals, split by which table held the conflicting line and by the kind of the new request.

Top module: `req_tracker`

## Requirements
- R1: Type codes 2 to 8 (store 2, read-modify-write read 3, read-modify-write write 4, load-linked 5, store-conditional 6, locked read-modify-write read 7, locked read-modify-write write 8) are held in the write table. Codes 0 (load) and 1 (instruction fetch) are held in the read table. A completion retires an entry only when its kind (`cpl_write`) names the table that holds the line.
- R2: A request whose line address (byte address with the low log2(LINE_BYTES) bits cleared) is present in either table gets status 1 (aliased), and no entry is allocated.
- R3: A legal request with no alias gets status 2 (full) when the occupancy is at or above MAX_OUT. The alias check takes precedence over this capacity check, and occupancy never exceeds MAX_OUT.
- R4: Any other legal request gets status 0 (issued). The occupancy rises by one, and `dn_valid` pulses in the same cycle as the response.
- R5: Downstream class: instruction fetch gives 0, load gives 1, store and all four read-modify-write kinds give 2, load-linked and store-conditional give 3. `dn_line` is the line address. `dn_priv` is 1 only for access mode 1 (supervisor); modes 0, 2 and 3 give 0.
- R6: On an alias refusal where the line is in the write table, `stall_st_ld` counts when the new type is 0, 1 or 3, and `stall_st_st` counts otherwise. Where the line is only in the read table, `stall_ld_st` counts when the new type is 2 or 4, and `stall_ld_ld` counts otherwise.
- R7: A matching completion removes the entry and lowers the occupancy by one, so the line can be issued again.
- R8: A completion with no matching entry sets `cpl_err`, which stays set until reset, and leaves the occupancy unchanged.
- R9: A request whose line offset plus length exceeds LINE_BYTES, or whose type code is above 8, gets status 3 (rejected). This check precedes the alias and capacity checks.
- R10: When any live entry's age (current cycle minus issue cycle) reaches DL_THRESH, `dl_flag` rises and stays set, and `dl_line` holds that entry's line address.
- R11: `inv_ok` is 1 in every cycle, meaning the occupancy equals the number of valid read entries plus valid write entries.
- R12: After reset the occupancy is 0, there is no response or downstream pulse, all stall counters are 0, and `cpl_err` and `dl_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | New request present |
| req_type | input | 4 | Request type code |
| req_addr | input | ADDR_W | Byte address |
| req_len | input | log2(LINE_BYTES)+1 | Length in bytes |
| req_mode | input | 2 | Access mode (0 user, 1 supervisor, 2 device) |
| cpl_valid | input | 1 | Completion present |
| cpl_write | input | 1 | Completion is for the write table |
| cpl_line | input | ADDR_W | Completed line address |
| rsp_valid | output | 1 | Response to last request |
| rsp_status | output | 2 | 0 issued, 1 aliased, 2 full, 3 rejected |
| dn_valid | output | 1 | Downstream request pulse |
| dn_class | output | 2 | Downstream class |
| dn_line | output | ADDR_W | Downstream line address |
| dn_priv | output | 1 | Supervisor access |
| occupancy | output | log2(MAX_OUT+1) | Outstanding requests |
| inv_ok | output | 1 | Occupancy matches table contents |
| cpl_err | output | 1 | Sticky unmatched completion |
| dl_flag | output | 1 | Sticky deadlock flag |
| dl_line | output | ADDR_W | Line of the first aged entry |
| stall_st_ld | output | CNT_W | Write-table alias, load-like request |
| stall_st_st | output | CNT_W | Write-table alias, other request |
| stall_ld_ld | output | CNT_W | Read-table alias, other request |
| stall_ld_st | output | CNT_W | Read-table alias, store-like request |

## Verification
The hardest conditions to reach are those where two refusal causes overlap. The stimulus first fills the tracker to MAX_OUT with a mix of read and write entries. While it is full, the bench sends a request that also aliases, one with an overrun length, and one with an unknown type. This shows that the alias and legality checks outrank capacity. Completions of the wrong kind for a live write entry come next, to show that the table split matters on retirement. The watchdog is reached only after the tables are emptied and a single entry is left to age, with samples taken both before and after the threshold.

// File: rtl/req_tracker_pkg.sv
package req_tracker_pkg;

  // request type codes seen at the processor port
  localparam logic [3:0] K_LOAD    = 4'd0;
  localparam logic [3:0] K_FETCH   = 4'd1;
  localparam logic [3:0] K_STORE   = 4'd2;
  localparam logic [3:0] K_RMW_RD  = 4'd3;
  localparam logic [3:0] K_RMW_WR  = 4'd4;
  localparam logic [3:0] K_LINKED  = 4'd5;
  localparam logic [3:0] K_COND    = 4'd6;
  localparam logic [3:0] K_LRMW_RD = 4'd7;
  localparam logic [3:0] K_LRMW_WR = 4'd8;

  typedef enum logic [1:0] {
    S_ISSUED  = 2'd0,
    S_ALIASED = 2'd1,
    S_FULL    = 2'd2,
    S_REJECT  = 2'd3
  } rsp_status_e;

  typedef enum logic [1:0] {
    C_FETCH  = 2'd0,
    C_LOAD   = 2'd1,
    C_STORE  = 2'd2,
    C_ATOMIC = 2'd3
  } dn_class_e;

endpackage

// File: rtl/req_decode.sv
module req_decode
  import req_tracker_pkg::*;
(
  input  logic [3:0] kind,
  input  logic [1:0] mode,
  output logic       legal,
  output logic       is_write,
  output logic       load_like,
  output logic       store_like,
  output logic [1:0] dn_class,
  output logic       priv
);

  always_comb begin
    legal      = 1'b1;
    is_write   = 1'b1;
    load_like  = 1'b0;
    store_like = 1'b0;
    dn_class   = C_STORE;
    case (kind)
      K_LOAD:    begin is_write = 1'b0; load_like = 1'b1; dn_class = C_LOAD; end
      K_FETCH:   begin is_write = 1'b0; load_like = 1'b1; dn_class = C_FETCH; end
      K_STORE:   store_like = 1'b1;
      K_RMW_RD:  load_like  = 1'b1;
      K_RMW_WR:  store_like = 1'b1;
      K_LINKED:  dn_class = C_ATOMIC;
      K_COND:    dn_class = C_ATOMIC;
      K_LRMW_RD: dn_class = C_STORE;
      K_LRMW_WR: dn_class = C_STORE;
      default:   begin legal = 1'b0; is_write = 1'b0; end
    endcase
  end

  assign priv = (mode == 2'd1);

endmodule

// File: rtl/req_table.sv
module req_table #(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int TW    = 16,
  parameter int TH    = 200,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [TW-1:0] now,
  input  logic [AW-1:0] look_line,
  output logic          look_hit,
  input  logic          alloc,
  input  logic [AW-1:0] alloc_line,
  input  logic          rel,
  input  logic [AW-1:0] rel_line,
  output logic          rel_hit,
  output logic [CW-1:0] count,
  output logic          aged,
  output logic [AW-1:0] aged_line
);

  logic [DEPTH-1:0] vld_q;
  logic [AW-1:0]    line_q [DEPTH];
  logic [TW-1:0]    born_q [DEPTH];

  logic [DEPTH-1:0] look_m, rel_m, old_m, free_oh;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    assign look_m[i] = vld_q[i] && (line_q[i] == look_line);
    assign rel_m[i]  = vld_q[i] && (line_q[i] == rel_line);
    assign old_m[i]  = vld_q[i] && (TW'(now - born_q[i]) >= TW'(TH));
  end

  // lowest empty slot, one-hot
  assign free_oh  = (~vld_q) & (vld_q + DEPTH'(1));
  assign look_hit = |look_m;
  assign rel_hit  = |rel_m;
  assign aged     = |old_m;

  always_comb begin
    aged_line = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (old_m[i]) aged_line = line_q[i];
  end

  always_comb begin
    count = '0;
    for (int i = 0; i < DEPTH; i++)
      count = count + CW'(vld_q[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (alloc && free_oh[i]) begin
          vld_q[i]  <= 1'b1;
          line_q[i] <= alloc_line;
          born_q[i] <= now;
        end else if (rel && rel_m[i]) begin
          vld_q[i] <= 1'b0;
        end
      end
    end
  end

  // R2
  no_dup_line_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(look_m));

  // R3
  alloc_room_chk: assert property (@(posedge clk) disable iff (rst)
    alloc |-> (free_oh != '0));

endmodule

// File: rtl/req_tracker.sv
module req_tracker
  import req_tracker_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int MAX_OUT    = 4,
  parameter int TIME_W     = 16,
  parameter int DL_THRESH  = 200,
  parameter int CNT_W      = 16,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int LEN_W     = OFF_W + 1,
  localparam int OCC_W     = $clog2(MAX_OUT + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [3:0]        req_type,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [1:0]        req_mode,
  input  logic              cpl_valid,
  input  logic              cpl_write,
  input  logic [ADDR_W-1:0] cpl_line,
  output logic              rsp_valid,
  output logic [1:0]        rsp_status,
  output logic              dn_valid,
  output logic [1:0]        dn_class,
  output logic [ADDR_W-1:0] dn_line,
  output logic              dn_priv,
  output logic [OCC_W-1:0]  occupancy,
  output logic              inv_ok,
  output logic              cpl_err,
  output logic              dl_flag,
  output logic [ADDR_W-1:0] dl_line,
  output logic [CNT_W-1:0]  stall_st_ld,
  output logic [CNT_W-1:0]  stall_st_st,
  output logic [CNT_W-1:0]  stall_ld_ld,
  output logic [CNT_W-1:0]  stall_ld_st
);

  localparam int SW = OCC_W + 1;

  logic              legal, is_write, load_like, store_like, priv;
  logic [1:0]        cls;
  logic [ADDR_W-1:0] req_line, rel_line;
  logic [LEN_W:0]    len_sum;
  logic              len_bad;
  logic              rd_look, wr_look, rd_rel, wr_rel, rd_aged, wr_aged;
  logic [ADDR_W-1:0] rd_aged_line, wr_aged_line;
  logic [OCC_W-1:0]  rd_cnt, wr_cnt;
  rsp_status_e       status_d;
  logic              accept, retire;

  logic [TIME_W-1:0] now_q;
  logic [OCC_W-1:0]  occ_q;
  logic              err_q, dl_q;
  logic [ADDR_W-1:0] dl_line_q;

  req_decode i_dec (
    .kind      (req_type),
    .mode      (req_mode),
    .legal     (legal),
    .is_write  (is_write),
    .load_like (load_like),
    .store_like(store_like),
    .dn_class  (cls),
    .priv      (priv)
  );

  assign req_line = {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign rel_line = {cpl_line[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign len_sum  = (LEN_W+1)'(req_addr[OFF_W-1:0]) + (LEN_W+1)'(req_len);
  assign len_bad  = len_sum > (LEN_W+1)'(LINE_BYTES);

  always_comb begin
    if (!legal || len_bad)          status_d = S_REJECT;
    else if (rd_look || wr_look)    status_d = S_ALIASED;
    else if (occ_q >= OCC_W'(MAX_OUT)) status_d = S_FULL;
    else                            status_d = S_ISSUED;
  end

  assign accept = req_valid && (status_d == S_ISSUED);
  assign retire = cpl_valid && (cpl_write ? wr_rel : rd_rel);

  req_table #(.DEPTH(MAX_OUT), .AW(ADDR_W), .TW(TIME_W), .TH(DL_THRESH)) i_rd_tab (
    .clk       (clk),
    .rst       (rst),
    .now       (now_q),
    .look_line (req_line),
    .look_hit  (rd_look),
    .alloc     (accept && !is_write),
    .alloc_line(req_line),
    .rel       (cpl_valid && !cpl_write),
    .rel_line  (rel_line),
    .rel_hit   (rd_rel),
    .count     (rd_cnt),
    .aged      (rd_aged),
    .aged_line (rd_aged_line)
  );

  req_table #(.DEPTH(MAX_OUT), .AW(ADDR_W), .TW(TIME_W), .TH(DL_THRESH)) i_wr_tab (
    .clk       (clk),
    .rst       (rst),
    .now       (now_q),
    .look_line (req_line),
    .look_hit  (wr_look),
    .alloc     (accept && is_write),
    .alloc_line(req_line),
    .rel       (cpl_valid && cpl_write),
    .rel_line  (rel_line),
    .rel_hit   (wr_rel),
    .count     (wr_cnt),
    .aged      (wr_aged),
    .aged_line (wr_aged_line)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      now_q       <= '0;
      occ_q       <= '0;
      err_q       <= 1'b0;
      dl_q        <= 1'b0;
      dl_line_q   <= '0;
      rsp_valid   <= 1'b0;
      rsp_status  <= S_ISSUED;
      dn_valid    <= 1'b0;
      dn_class    <= C_FETCH;
      dn_line     <= '0;
      dn_priv     <= 1'b0;
      stall_st_ld <= '0;
      stall_st_st <= '0;
      stall_ld_ld <= '0;
      stall_ld_st <= '0;
    end else begin
      now_q      <= now_q + TIME_W'(1);
      occ_q      <= occ_q + OCC_W'(accept) - OCC_W'(retire);
      rsp_valid  <= req_valid;
      rsp_status <= status_d;
      dn_valid   <= accept;
      if (accept) begin
        dn_class <= cls;
        dn_line  <= req_line;
        dn_priv  <= priv;
      end
      if (cpl_valid && !retire) err_q <= 1'b1;
      if (!dl_q && (rd_aged || wr_aged)) begin
        dl_q      <= 1'b1;
        dl_line_q <= wr_aged ? wr_aged_line : rd_aged_line;
      end
      if (req_valid && status_d == S_ALIASED) begin
        if (wr_look) begin
          if (load_like) begin
            if (stall_st_ld != '1) stall_st_ld <= stall_st_ld + CNT_W'(1);
          end else begin
            if (stall_st_st != '1) stall_st_st <= stall_st_st + CNT_W'(1);
          end
        end else begin
          if (store_like) begin
            if (stall_ld_st != '1) stall_ld_st <= stall_ld_st + CNT_W'(1);
          end else begin
            if (stall_ld_ld != '1) stall_ld_ld <= stall_ld_ld + CNT_W'(1);
          end
        end
      end
    end
  end

  assign occupancy = occ_q;
  assign cpl_err   = err_q;
  assign dl_flag   = dl_q;
  assign dl_line   = dl_line_q;
  assign inv_ok    = (SW'(occ_q) == SW'(rd_cnt) + SW'(wr_cnt));

  // R11
  inv_hold_chk: assert property (@(posedge clk) disable iff (rst) inv_ok);

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    occ_q <= OCC_W'(MAX_OUT));

  // R4
  dn_with_issue_chk: assert property (@(posedge clk) disable iff (rst)
    dn_valid |-> (rsp_valid && rsp_status == S_ISSUED));

  // R2
  alias_no_grow_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_status == S_ALIASED) |-> (occ_q <= $past(occ_q)));

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst) !$fell(err_q));

  // R10
  dl_sticky_chk: assert property (@(posedge clk) disable iff (rst) !$fell(dl_q));

  // R10
  dl_line_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (dl_q && $past(dl_q)) |-> $stable(dl_line_q));

endmodule

// File: tb/test_req_tracker.sv
module test_req_tracker;

  localparam int AW = 32;
  localparam int TH = 100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic          req_valid = 1'b0;
  logic [3:0]    req_type  = '0;
  logic [AW-1:0] req_addr  = '0;
  logic [6:0]    req_len   = '0;
  logic [1:0]    req_mode  = '0;
  logic          cpl_valid = 1'b0;
  logic          cpl_write = 1'b0;
  logic [AW-1:0] cpl_line  = '0;

  logic          rsp_valid, dn_valid, dn_priv, inv_ok, cpl_err, dl_flag;
  logic [1:0]    rsp_status, dn_class;
  logic [AW-1:0] dn_line, dl_line;
  logic [2:0]    occupancy;
  logic [15:0]   stall_st_ld, stall_st_st, stall_ld_ld, stall_ld_st;

  req_tracker #(.DL_THRESH(TH)) i_req_tracker (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_type(req_type), .req_addr(req_addr),
    .req_len(req_len), .req_mode(req_mode),
    .cpl_valid(cpl_valid), .cpl_write(cpl_write), .cpl_line(cpl_line),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status),
    .dn_valid(dn_valid), .dn_class(dn_class), .dn_line(dn_line), .dn_priv(dn_priv),
    .occupancy(occupancy), .inv_ok(inv_ok), .cpl_err(cpl_err),
    .dl_flag(dl_flag), .dl_line(dl_line),
    .stall_st_ld(stall_st_ld), .stall_st_st(stall_st_st),
    .stall_ld_ld(stall_ld_ld), .stall_ld_st(stall_ld_st)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [1:0]    st;
    logic [1:0]    cls;
    logic [AW-1:0] line;
    logic          priv;
    string         tag;
  } exp_t;

  exp_t sb[$];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
    chk(act == exp, tag, act, exp);
  endtask

  // driver: pushes the expected response, monitor compares it
  task automatic send(input logic [3:0] t, input logic [AW-1:0] a, input logic [6:0] l,
                      input logic [1:0] m, input logic [1:0] est, input logic [1:0] ecls,
                      input logic epriv, input string tag);
    exp_t e;
    @(negedge clk);
    req_valid = 1'b1; req_type = t; req_addr = a; req_len = l; req_mode = m;
    e.st = est; e.cls = ecls; e.line = a & ~32'h3F; e.priv = epriv; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic cpl(input logic w, input logic [AW-1:0] line);
    @(negedge clk);
    cpl_valid = 1'b1; cpl_write = w; cpl_line = line;
    @(negedge clk);
    cpl_valid = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (!inv_ok) begin
        checks++; fails++;
        $display("FAIL R11 inv_ok actual=0 expected=1");
      end
      if (rsp_valid) begin
        if (sb.size() == 0) begin
          checks++; fails++;
          $display("FAIL R4 unexpected response actual=%0d expected=none", rsp_status);
        end else begin
          exp_t e;
          e = sb.pop_front();
          eq({e.tag, " status"}, 64'(rsp_status), 64'(e.st));
          if (e.st == 2'd0) begin
            eq({e.tag, " R4 dn_valid"}, 64'(dn_valid), 64'd1);
            eq({e.tag, " R5 class"}, 64'(dn_class), 64'(e.cls));
            eq({e.tag, " R5 line"}, 64'(dn_line), 64'(e.line));
            eq({e.tag, " R5 priv"}, 64'(dn_priv), 64'(e.priv));
          end else begin
            eq({e.tag, " R4 no dn"}, 64'(dn_valid), 64'd0);
          end
        end
      end else if (dn_valid) begin
        checks++; fails++;
        $display("FAIL R4 dn_valid without response actual=1 expected=0");
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    eq("R12 occupancy", 64'(occupancy), 0);
    eq("R12 rsp_valid", 64'(rsp_valid), 0);
    eq("R12 dn_valid", 64'(dn_valid), 0);
    eq("R12 cpl_err", 64'(cpl_err), 0);
    eq("R12 dl_flag", 64'(dl_flag), 0);
    eq("R12 stalls", 64'(stall_st_ld | stall_st_st | stall_ld_ld | stall_ld_st), 0);

    // R4 R5 issues
    send(4'd0, 32'h100, 7'd4, 2'd0, 2'd0, 2'd1, 1'b0, "R4 load");
    send(4'd1, 32'h208, 7'd8, 2'd1, 2'd0, 2'd0, 1'b1, "R5 fetch supervisor");
    eq("R4 occupancy 2", 64'(occupancy), 2);
    // R2 R6 store hitting a read-table line
    send(4'd2, 32'h13C, 7'd4, 2'd0, 2'd1, 2'd0, 1'b0, "R2 store alias");
    eq("R2 occupancy unchanged", 64'(occupancy), 2);
    eq("R6 ld_st", 64'(stall_ld_st), 1);
    send(4'd5, 32'h300, 7'd8, 2'd2, 2'd0, 2'd3, 1'b0, "R5 linked device");
    send(4'd0, 32'h310, 7'd4, 2'd0, 2'd1, 2'd0, 1'b0, "R2 load on write line");
    eq("R6 st_ld", 64'(stall_st_ld), 1);
    send(4'd6, 32'h300, 7'd4, 2'd0, 2'd1, 2'd0, 1'b0, "R2 cond on write line");
    eq("R6 st_st", 64'(stall_st_st), 1);
    send(4'd1, 32'h220, 7'd4, 2'd0, 2'd1, 2'd0, 1'b0, "R2 fetch on read line");
    eq("R6 ld_ld", 64'(stall_ld_ld), 1);
    send(4'd4, 32'h400, 7'd16, 2'd3, 2'd0, 2'd2, 1'b0, "R5 rmw write");
    eq("R3 occupancy full", 64'(occupancy), 4);
    // R3 capacity and precedence
    send(4'd0, 32'h500, 7'd4, 2'd0, 2'd2, 2'd0, 1'b0, "R3 full");
    send(4'd2, 32'h100, 7'd4, 2'd0, 2'd1, 2'd0, 1'b0, "R3 alias beats full");
    eq("R6 ld_st 2", 64'(stall_ld_st), 2);
    // R9 legality before alias and capacity
    send(4'd0, 32'h53C, 7'd5, 2'd0, 2'd3, 2'd0, 1'b0, "R9 overrun");
    send(4'd0, 32'h13C, 7'd8, 2'd0, 2'd3, 2'd0, 1'b0, "R9 overrun beats alias");
    send(4'd9, 32'h500, 7'd4, 2'd0, 2'd3, 2'd0, 1'b0, "R9 bad type");
    send(4'd0, 32'h540, 7'd64, 2'd0, 2'd2, 2'd0, 1'b0, "R9 exact line fits");
    eq("R9 occupancy", 64'(occupancy), 4);
    // R1 R8 wrong-kind completion
    cpl(1'b0, 32'h300);
    eq("R8 cpl_err", 64'(cpl_err), 1);
    eq("R1 wrong kind keeps entry", 64'(occupancy), 4);
    // R1 R7 retire
    cpl(1'b1, 32'h300);
    eq("R7 occupancy after retire", 64'(occupancy), 3);
    send(4'd5, 32'h300, 7'd4, 2'd0, 2'd0, 2'd3, 1'b0, "R7 reissue");
    cpl(1'b0, 32'h100);
    cpl(1'b0, 32'h200);
    cpl(1'b1, 32'h400);
    cpl(1'b1, 32'h300);
    eq("R7 drained", 64'(occupancy), 0);
    eq("R8 cpl_err sticky", 64'(cpl_err), 1);
    cpl(1'b1, 32'h800);
    eq("R8 miss keeps occupancy", 64'(occupancy), 0);
    eq("R10 no flag yet", 64'(dl_flag), 0);

    // R10 watchdog
    send(4'd0, 32'h640, 7'd4, 2'd0, 2'd0, 2'd1, 1'b0, "R10 issue");
    repeat (TH - 10) @(negedge clk);
    eq("R10 before threshold", 64'(dl_flag), 0);
    repeat (20) @(negedge clk);
    eq("R10 after threshold", 64'(dl_flag), 1);
    eq("R10 dl_line", 64'(dl_line), 64'h640);
    cpl(1'b0, 32'h640);
    eq("R10 flag sticky", 64'(dl_flag), 1);

    @(negedge clk);
    eq("R4 scoreboard empty", 64'(sb.size()), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule